// File: doc/BRIEF.md
# Dual-Style Peripheral Bus Interface

This block is the peripheral end of an 8/16-bit processor bus. Static configuration inputs choose how it behaves. A slave access can be signalled in one of two ways: by a data strobe together with a direction line, or by separate read and write strobes. Chip select must be asserted in both cases. Every asynchronous bus control input passes through a two-flop synchroniser first. The block then issues one-cycle read and write strobes towards the internal registers. Read data goes onto the bus after a fixed internal latency.

One handshake pin carries the bus-cycle handshake, and configuration sets its meaning. In wait style the pin is pulled low to hold off the processor until the access can complete. In ready style the pin is pulled low to acknowledge that the access is complete. While the internal DMA engine owns the bus, the block releases the pin and samples it as an input instead. In that case the pin tells the engine when its own transfer may finish.

For DMA byte transfers, an optional swap mode places each byte on one half of the 16-bit data bus. The half is chosen by address bit 0, and a select bit can invert that choice. With swapping off, DMA words cross the bus unchanged.

Top module: `pbi_dual_bus`

## Requirements
- R1: Out of reset, hs_oe is 1, hs_out is 1 (idle), bus_oe is 0, and reg_rd_stb and reg_wr_stb are 0.
- R2: While cs_n is 1, no strobe toggling produces reg_rd_stb, reg_wr_stb or bus_oe, and hs_out stays at its idle level 1.
- R3: With cfg_sep_strobes=0, an access is ds_n=0 with cs_n=0, and rw=1 marks a read. During a read, bus_oe is 1, and reg_rd_stb pulses for exactly one cycle, 2 clocks after the inputs change.
- R4: With cfg_sep_strobes=1, rd_n=0 marks a read access and wr_n=0 marks a write access, both qualified by cs_n=0. In this mode rw and ds_n have no effect.
- R5: An access is recognised 2 clocks after its inputs change, because of the synchroniser. The handshake shows not-ready for RD_LAT=2 further clocks. When it turns ready, bus_dout holds the reg_rdata value sampled during the access.
- R6: With cfg_hs_ready=0 (wait style) and the block not bus master, hs_out is 0 from recognition until the latency expires, and is 1 otherwise.
- R7: With cfg_hs_ready=1 (ready style) and the block not bus master, hs_out is 0 only while the access is recognised and ready, and is 1 otherwise.
- R8: A write access produces exactly one reg_wr_stb pulse, 3 clocks after the inputs change, with reg_wdata equal to bus_din.
- R9: With dma_owner=1, hs_oe is 0 and hs_in is synchronised in 2 clocks. Wait style sets dma_ack=dma_xfer when hs_in is 1. Ready style sets dma_ack=dma_xfer when hs_in is 0.
- R10: With cfg_swap_en=1 and cfg_swap_sel=1, a DMA byte at dma_a0=0 uses bus bits 7:0 and a byte at dma_a0=1 uses bits 15:8. The other half of bus_dout is 0, and dma_rdata carries the selected half in bits 7:0 with zeros above.
- R11: With cfg_swap_en=1 and cfg_swap_sel=0, the half mapping of R10 is reversed.
- R12: With cfg_swap_en=0, a DMA write drives dma_wdata unchanged onto bus_dout, and dma_rdata equals bus_din. bus_oe is 1 during a DMA transfer only when dma_wr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sep_strobes | input | 1 | 0: data strobe plus rw, 1: separate rd_n/wr_n |
| cfg_hs_ready | input | 1 | 0: wait style handshake, 1: ready style |
| cfg_swap_en | input | 1 | Enable DMA byte lane steering |
| cfg_swap_sel | input | 1 | Lane mapping select |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | Direction, 1 = read |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 16 | Data bus inbound |
| bus_dout | output | 16 | Data bus outbound |
| bus_oe | output | 1 | Data bus drive enable |
| hs_in | input | 1 | Handshake pin inbound |
| hs_out | output | 1 | Handshake pin outbound |
| hs_oe | output | 1 | Handshake pin drive enable |
| reg_rdata | input | 16 | Internal register read data |
| reg_wdata | output | 16 | Internal register write data |
| reg_rd_stb | output | 1 | One-cycle internal read strobe |
| reg_wr_stb | output | 1 | One-cycle internal write strobe |
| dma_owner | input | 1 | DMA engine owns the bus |
| dma_xfer | input | 1 | DMA transfer in progress |
| dma_wr | input | 1 | DMA transfer drives the bus |
| dma_a0 | input | 1 | DMA address bit 0 |
| dma_wdata | input | 16 | DMA outbound data (byte in bits 7:0 when swapping) |
| dma_rdata | output | 16 | DMA inbound data |
| dma_ack | output | 1 | DMA transfer may complete |

## Verification
A wrong latency counter or synchroniser depth changes the cycle in which hs_out changes or reg_rd_stb pulses. That error shows at the ports within two to four clocks of a strobe edge, so each check samples the exact cycle. A wrong strobe-style decode shows up as a missing strobe or a spurious one, or as bus_oe driven on a write. An inverted handshake polarity makes the pin idle at the wrong level straight after reset. An inverted lane select puts a DMA byte on the wrong half of the bus at once, because the steering is combinational.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
   localparam int unsigned BUS_W    = 16;
   localparam int unsigned LANE_W   = 8;
   localparam int unsigned N_LANES  = BUS_W / LANE_W;
   localparam int unsigned N_CTRL   = 5;
   // control vector positions
   localparam int unsigned C_CS = 0;
   localparam int unsigned C_DS = 1;
   localparam int unsigned C_RW = 2;
   localparam int unsigned C_RD = 3;
   localparam int unsigned C_WR = 4;
   localparam logic [N_CTRL-1:0] CTRL_IDLE = '1;

   typedef enum logic {HS_WAIT = 1'b0, HS_READY = 1'b1} hs_style_e;

   // choose upper lane for a DMA byte
   function automatic logic upper_lane(input logic a0, input logic sel);
      return sel ? a0 : ~a0;
   endfunction
endpackage

// File: rtl/pbi_sync.sv
module pbi_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pbi_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else if (i == 0) stg[i] <= d;
         else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pbi_slave_ctl.sv
module pbi_slave_ctl
   import pbi_pkg::*;
#(
   parameter int unsigned RD_LAT = 2,
   parameter int unsigned DW     = BUS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sep_strobes,
   input  logic          hs_ready_style,
   input  logic          blocked,
   input  logic [N_CTRL-1:0] ctrl_s,
   input  logic [DW-1:0] rdata_in,
   output logic [DW-1:0] rdata_q,
   output logic          rd_stb,
   output logic          wr_stb,
   output logic          drive_read,
   output logic          hs_level
);
   localparam int unsigned CW = $clog2(RD_LAT + 1);
   localparam logic [CW-1:0] LAT_C  = CW'(RD_LAT);
   localparam logic [CW-1:0] LAT_M1 = CW'(RD_LAT - 1);

   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end

   logic          sel, access, is_read, ready;
   logic [CW-1:0] cnt;

   assign sel = ~ctrl_s[C_CS] & ~blocked;

   always_comb begin
      if (sep_strobes) begin
         access  = sel & (~ctrl_s[C_RD] | ~ctrl_s[C_WR]);
         is_read = ~ctrl_s[C_RD];
      end else begin
         access  = sel & ~ctrl_s[C_DS];
         is_read = ctrl_s[C_RW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!access) cnt <= '0;
      else if (cnt != LAT_C) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (access && is_read && cnt == LAT_M1) rdata_q <= rdata_in;
   end

   assign ready      = access & (cnt == LAT_C);
   assign rd_stb     = access & is_read & (cnt == '0);
   assign wr_stb     = access & ~is_read & (cnt == LAT_M1);
   assign drive_read = access & is_read;
   assign hs_level   = (hs_ready_style == HS_READY) ? ~ready : ~(access & ~ready);

   AST_RD_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb); // R3
   AST_WR_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R8
   AST_NOT_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(access) |-> !ready); // R5
   AST_READY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $past(access)); // R5
endmodule

// File: rtl/pbi_lane_steer.sv
module pbi_lane_steer
   import pbi_pkg::*;
(
   input  logic             swap_en,
   input  logic             swap_sel,
   input  logic             a0,
   input  logic [BUS_W-1:0] wdata,
   input  logic [BUS_W-1:0] bus_in,
   output logic [BUS_W-1:0] bus_out,
   output logic [BUS_W-1:0] rdata
);
   logic [N_LANES-1:0] lane_en;
   logic [LANE_W-1:0]  rbyte;

   assign lane_en[1] = upper_lane(a0, swap_sel);
   assign lane_en[0] = ~lane_en[1];

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      assign bus_out[l*LANE_W +: LANE_W] = !swap_en ? wdata[l*LANE_W +: LANE_W]
                                         : (lane_en[l] ? wdata[LANE_W-1:0] : '0);
   end

   assign rbyte = lane_en[1] ? bus_in[BUS_W-1 -: LANE_W] : bus_in[LANE_W-1:0];
   assign rdata = swap_en ? {{(BUS_W-LANE_W){1'b0}}, rbyte} : bus_in;

   always_comb begin
      if (swap_en) begin
         AST_ONE_LANE_USED: assert (bus_out[BUS_W-1 -: LANE_W] == '0 ||
                                    bus_out[LANE_W-1:0] == '0); // R10
      end
   end
endmodule

// File: rtl/pbi_master_hs.sv
module pbi_master_hs
   import pbi_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_ready_style,
   input  logic hs_pin,
   input  logic xfer,
   output logic ack
);
   logic hs_s;

   pbi_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_hs_sync (
      .clk(clk), .rst_n(rst_n), .d(hs_pin), .q(hs_s));

   assign ack = xfer & ((hs_ready_style == HS_READY) ? ~hs_s : hs_s);

   AST_ACK_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> xfer); // R9
endmodule

// File: rtl/pbi_dual_bus.sv
module pbi_dual_bus
   import pbi_pkg::*;
#(
   parameter int unsigned RD_LAT      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_sep_strobes,
   input  logic             cfg_hs_ready,
   input  logic             cfg_swap_en,
   input  logic             cfg_swap_sel,
   input  logic             cs_n,
   input  logic             ds_n,
   input  logic             rw,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [BUS_W-1:0] bus_din,
   output logic [BUS_W-1:0] bus_dout,
   output logic             bus_oe,
   input  logic             hs_in,
   output logic             hs_out,
   output logic             hs_oe,
   input  logic [BUS_W-1:0] reg_rdata,
   output logic [BUS_W-1:0] reg_wdata,
   output logic             reg_rd_stb,
   output logic             reg_wr_stb,
   input  logic             dma_owner,
   input  logic             dma_xfer,
   input  logic             dma_wr,
   input  logic             dma_a0,
   input  logic [BUS_W-1:0] dma_wdata,
   output logic [BUS_W-1:0] dma_rdata,
   output logic             dma_ack
);
   if (BUS_W != N_LANES * LANE_W) begin : g_bad_bus
      $error("bus width must be a whole number of lanes");
   end

   logic [N_CTRL-1:0] ctrl_raw, ctrl_s;
   logic [BUS_W-1:0]  slv_dout, dma_dout;
   logic              slv_read, hs_level;

   always_comb begin
      ctrl_raw       = CTRL_IDLE;
      ctrl_raw[C_CS] = cs_n;
      ctrl_raw[C_DS] = ds_n;
      ctrl_raw[C_RW] = rw;
      ctrl_raw[C_RD] = rd_n;
      ctrl_raw[C_WR] = wr_n;
   end

   pbi_sync #(.WIDTH(N_CTRL), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s));

   pbi_slave_ctl #(.RD_LAT(RD_LAT), .DW(BUS_W)) u_slave (
      .clk(clk), .rst_n(rst_n),
      .sep_strobes(cfg_sep_strobes), .hs_ready_style(cfg_hs_ready),
      .blocked(dma_owner), .ctrl_s(ctrl_s),
      .rdata_in(reg_rdata), .rdata_q(slv_dout),
      .rd_stb(reg_rd_stb), .wr_stb(reg_wr_stb),
      .drive_read(slv_read), .hs_level(hs_level));

   pbi_lane_steer u_steer (
      .swap_en(cfg_swap_en), .swap_sel(cfg_swap_sel), .a0(dma_a0),
      .wdata(dma_wdata), .bus_in(bus_din),
      .bus_out(dma_dout), .rdata(dma_rdata));

   pbi_master_hs #(.STAGES(SYNC_STAGES)) u_mhs (
      .clk(clk), .rst_n(rst_n), .hs_ready_style(cfg_hs_ready),
      .hs_pin(hs_in), .xfer(dma_xfer & dma_owner), .ack(dma_ack));

   assign reg_wdata = bus_din;
   assign hs_oe     = ~dma_owner;
   assign hs_out    = dma_owner ? 1'b1 : hs_level;
   assign bus_oe    = dma_owner ? (dma_xfer & dma_wr) : slv_read;
   assign bus_dout  = dma_owner ? dma_dout : slv_dout;

   AST_MASTER_NO_SLAVE_STB: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dma_owner) && dma_owner |-> !reg_rd_stb && !reg_wr_stb); // R9
endmodule

// File: tb/pbi_dual_bus_tb.sv
module pbi_dual_bus_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic cfg_sep_strobes = 0, cfg_hs_ready = 0, cfg_swap_en = 0, cfg_swap_sel = 0;
   logic cs_n = 1, ds_n = 1, rw = 1, rd_n = 1, wr_n = 1, hs_in = 1;
   logic [15:0] bus_din = 0, reg_rdata = 0, dma_wdata = 0;
   logic dma_owner = 0, dma_xfer = 0, dma_wr = 0, dma_a0 = 0;
   logic [15:0] bus_dout, reg_wdata, dma_rdata;
   logic bus_oe, hs_out, hs_oe, reg_rd_stb, reg_wr_stb, dma_ack;

   int n_chk = 0, n_bad = 0;

   pbi_dual_bus dut_i (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 hs_oe", 16'(hs_oe), 16'd1);
      chk("R1 hs_out", 16'(hs_out), 16'd1);
      chk("R1 bus_oe", 16'(bus_oe), 16'd0);
      chk("R1 strobes", 16'({reg_rd_stb, reg_wr_stb}), 16'd0);
   endtask

   task automatic t_no_ce();
      int seen = 0;
      cfg_sep_strobes = 0; ds_n = 0; rw = 1;
      for (int i = 0; i < 6; i++) begin
         nclk(1);
         if (reg_rd_stb || reg_wr_stb || bus_oe || !hs_out) seen++;
      end
      ds_n = 1; cfg_sep_strobes = 1; rd_n = 0;
      for (int i = 0; i < 6; i++) begin
         nclk(1);
         if (reg_rd_stb || reg_wr_stb || bus_oe || !hs_out) seen++;
      end
      rd_n = 1; nclk(3);
      chk("R2 no activity without cs", 16'(seen), 16'd0);
   endtask

   // data strobe style read, wait style handshake
   task automatic t_ds_read_wait();
      cfg_sep_strobes = 0; cfg_hs_ready = 0; reg_rdata = 16'hA55A;
      cs_n = 0; rw = 1; ds_n = 0;
      nclk(2);
      chk("R3 rd_stb at 2", 16'(reg_rd_stb), 16'd1);
      chk("R3 bus_oe read", 16'(bus_oe), 16'd1);
      nclk(1);
      chk("R3 rd_stb single", 16'(reg_rd_stb), 16'd0);
      chk("R6 wait pin low", 16'(hs_out), 16'd0);
      nclk(1);
      chk("R6 wait pin high at ready", 16'(hs_out), 16'd1);
      chk("R5 read data", bus_dout, 16'hA55A);
      ds_n = 1; cs_n = 1; nclk(3);
      chk("R3 bus_oe released", 16'(bus_oe), 16'd0);
   endtask

   // separate strobes, ready style, write then read
   task automatic t_sep_ready();
      int wcnt = 0;
      cfg_sep_strobes = 1; cfg_hs_ready = 1; nclk(1);
      chk("R7 ready idle high", 16'(hs_out), 16'd1);
      bus_din = 16'h1234; ds_n = 1; rw = 1; cs_n = 0; wr_n = 0;
      nclk(2);
      chk("R4 write no oe", 16'(bus_oe), 16'd0);
      nclk(1);
      chk("R8 wr_stb at 3", 16'(reg_wr_stb), 16'd1);
      chk("R8 wdata", reg_wdata, 16'h1234);
      chk("R7 ready pin high before latency", 16'(hs_out), 16'd1);
      nclk(1);
      chk("R7 ready pin low at ready", 16'(hs_out), 16'd0);
      for (int i = 0; i < 4; i++) begin
         if (reg_wr_stb) wcnt++;
         nclk(1);
      end
      chk("R8 single write pulse", 16'(wcnt), 16'd0);
      wr_n = 1; cs_n = 1; nclk(3);
      chk("R7 pin idle after", 16'(hs_out), 16'd1);
      reg_rdata = 16'h0F0F; cs_n = 0; rd_n = 0; rw = 0;
      nclk(2);
      chk("R4 rd_stb ignores rw", 16'(reg_rd_stb), 16'd1);
      nclk(2);
      chk("R5 sep read data", bus_dout, 16'h0F0F);
      rd_n = 1; cs_n = 1; rw = 1; nclk(3);
   endtask

   task automatic t_master();
      dma_owner = 1; dma_xfer = 1; dma_wr = 0; cfg_hs_ready = 0; hs_in = 0;
      nclk(3);
      chk("R9 hs_oe released", 16'(hs_oe), 16'd0);
      chk("R9 wait holds", 16'(dma_ack), 16'd0);
      hs_in = 1; nclk(1);
      chk("R9 sync delay", 16'(dma_ack), 16'd0);
      nclk(1);
      chk("R9 wait release ack", 16'(dma_ack), 16'd1);
      cfg_hs_ready = 1; nclk(1);
      chk("R9 ready style not ack", 16'(dma_ack), 16'd0);
      hs_in = 0; nclk(2);
      chk("R9 ready style ack", 16'(dma_ack), 16'd1);
      cs_n = 0; ds_n = 0; nclk(4);
      chk("R9 slave ignored as master", 16'({reg_rd_stb, hs_oe}), 16'd0);
      cs_n = 1; ds_n = 1; hs_in = 1; nclk(3);
   endtask

   task automatic t_steer();
      dma_wr = 1; dma_wdata = 16'hBEC3; bus_din = 16'h7E81;
      cfg_swap_en = 1; cfg_swap_sel = 1; dma_a0 = 0; nclk(1);
      chk("R10 even lower", bus_dout, 16'h00C3);
      chk("R10 even read", dma_rdata, 16'h0081);
      dma_a0 = 1; nclk(1);
      chk("R10 odd upper", bus_dout, 16'hC300);
      chk("R10 odd read", dma_rdata, 16'h007E);
      cfg_swap_sel = 0; nclk(1);
      chk("R11 odd lower", bus_dout, 16'h00C3);
      dma_a0 = 0; nclk(1);
      chk("R11 even upper", bus_dout, 16'hC300);
      chk("R11 even read", dma_rdata, 16'h007E);
      cfg_swap_en = 0; nclk(1);
      chk("R12 passthrough", bus_dout, 16'hBEC3);
      chk("R12 read passthrough", dma_rdata, 16'h7E81);
      chk("R12 oe on write", 16'(bus_oe), 16'd1);
      dma_wr = 0; nclk(1);
      chk("R12 no oe on read", 16'(bus_oe), 16'd0);
      dma_xfer = 0; dma_owner = 0; nclk(3);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      nclk(2);
      rst_n = 1;
      nclk(2);
      t_reset();
      t_no_ce();
      t_ds_read_wait();
      t_sep_ready();
      t_master();
      t_steer();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule